// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the serial front end of a register-based peripheral that sits on a two-wire bus. It oversamples the clock and data lines on the system clock and finds start and stop conditions. It takes the first byte of each transfer and compares it against a fixed four-bit device-type code and three strap pins. It then acknowledges, collects command and data bytes for a command engine, or shifts out bytes that the engine supplies. Each received byte reaches the engine with a one-cycle strobe. The start and end of each transfer that selects this slave are also marked with one-cycle strobes.

While the engine reports a nonvolatile write in progress on `busy_i`, the slave withholds the acknowledge for its own address. A master can therefore poll for completion by repeating a start and the address until the acknowledge returns. The data line is modelled as an open-drain pull-down enable. Pad behaviour, clock stretching and arbitration belong to other blocks. The system clock must run at least eight times faster than the bus clock.

Top module: `twi_slave_front`

## Requirements
- R1: After reset the pull-down enable is released and no strobe is asserted.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Until the first start, no bus activity produces an acknowledge or a strobe.
- R3: The address byte is taken MSB first with bit order [7:4] = 4'b0101, [3:1] = `addr_pins_i`, [0] = direction (1 = read). On a match, the line is pulled low for the ninth clock and `frame_start_o` pulses once, with `frame_rnw_o` carrying the direction bit. Each of the eight pin settings selects only its own address.
- R4: An address byte with a wrong type code or wrong pin bits gets no acknowledge. The bytes that follow it get no acknowledge and no strobe until the next start.
- R5: While `busy_i` is high at the end of the address byte, the address gets no acknowledge and `frame_start_o` stays low. Once `busy_i` is low, a new start with the same address is acknowledged.
- R6: In a write transfer, each byte after the address is sampled MSB first on the clock's rising edges and acknowledged. It is presented on `rx_byte_o` with a one-cycle `rx_valid_o`. `rx_first_o` is high with that strobe only for the first byte after the address.
- R7: In a read transfer, `tx_byte_i` is captured when `tx_load_o` pulses. This happens at the clock fall that ends the acknowledge. The byte is sent MSB first, and a 0 bit pulls the line low.
- R8: A low master acknowledge after a read byte loads and sends another byte. A high one releases the line and ends the transfer, and the following clocks get no response.
- R9: A start at any point restarts address reception, including a repeated start in the middle of a byte. A stop returns the block to idle. Either one pulses `frame_end_o` if a transfer had selected this slave.
- R10: The pull-down enable changes only after a synchronized clock fall, a start or a stop. The line therefore never changes while the clock is high, except for the master's own conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| addr_pins_i | input | 3 | Strap pins for the low address bits |
| busy_i | input | 1 | Engine busy with a nonvolatile write |
| frame_start_o | output | 1 | Pulse: own address acknowledged |
| frame_rnw_o | output | 1 | Direction of the selected transfer, 1 = read |
| frame_end_o | output | 1 | Pulse: selected transfer ended by start or stop |
| rx_valid_o | output | 1 | Pulse: received byte on rx_byte_o |
| rx_first_o | output | 1 | Received byte is the first after the address |
| rx_byte_o | output | 8 | Received byte |
| tx_load_o | output | 1 | Pulse: tx_byte_i captured for sending |
| tx_byte_i | input | 8 | Byte to send in a read transfer |

## Verification
The bench goes after clocked bytes sent before any start. A design that did not ignore them would acknowledge a lone address. It also covers a wrong type code, wrong pin bits, and address polling while busy. A design that got these wrong would pull the line low for a foreign address or during a write cycle. A repeated start halfway through a command byte exposes a bit counter that does not clear: the next address would then be framed across a misaligned byte. Reads with a master acknowledge and then a non-acknowledge show whether the second byte is fetched and whether the line is released afterwards. A slave that kept driving would corrupt the master's stop.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W  = 3;
  localparam int TYPE_W = BYTE_W - 1 - PIN_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [TYPE_W-1:0] DEV_TYPE = TYPE_W'(5);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_TMORE
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              oe_o,
  output logic              fs_o,
  output logic              rnw_o,
  output logic              fe_o,
  output logic              rxv_o,
  output logic              rxf_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              txl_o
);
  twi_state_e state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic oe_q, oe_d, sel_q, sel_d, rnw_q, rnw_d, first_q, first_d;
  logic fs_q, fs_d, fe_q, fe_d, rxv_q, rxv_d, rxf_q, rxf_d, txl_q, txl_d;
  logic byte_done, addr_hit;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (sh_q[BYTE_W-1 -: TYPE_W] == DEV_TYPE) && (sh_q[PIN_W:1] == pins_i);

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; rx_d = rx_q;
    oe_d = oe_q; sel_d = sel_q; rnw_d = rnw_q; first_d = first_q;
    fs_d = 1'b0; fe_d = 1'b0; rxv_d = 1'b0; rxf_d = 1'b0; txl_d = 1'b0;
    if (start_i) begin
      fe_d = sel_q; sel_d = 1'b0; state_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_i) begin
      fe_d = sel_q; sel_d = 1'b0; state_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i && !byte_done) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall_i && byte_done) begin
            if (state_q == ST_RX) begin
              oe_d = 1'b1; state_d = ST_RACK; rx_d = sh_q; rxv_d = 1'b1;
              rxf_d = first_q; first_d = 1'b0;
            end else if (addr_hit && !busy_i) begin
              oe_d = 1'b1; state_d = ST_AACK; sel_d = 1'b1; fs_d = 1'b1;
              rnw_d = sh_q[0]; first_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_TMORE: begin
          if (scl_fall_i) begin
            cnt_d = '0;
            if (rnw_q) begin
              sh_d = tx_byte_i; oe_d = ~tx_byte_i[BYTE_W-1]; txl_d = 1'b1; state_d = ST_TX;
            end else begin
              oe_d = 1'b0; state_d = ST_RX;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall_i) begin
            oe_d = 1'b0; cnt_d = '0; state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              oe_d = 1'b0; state_d = ST_TACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0}; oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise_i) state_d = sda_i ? ST_IDLE : ST_TMORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rx_q <= '0;
      oe_q <= 1'b0; sel_q <= 1'b0; rnw_q <= 1'b0; first_q <= 1'b0;
      fs_q <= 1'b0; fe_q <= 1'b0; rxv_q <= 1'b0; rxf_q <= 1'b0; txl_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; rx_q <= rx_d;
      oe_q <= oe_d; sel_q <= sel_d; rnw_q <= rnw_d; first_q <= first_d;
      fs_q <= fs_d; fe_q <= fe_d; rxv_q <= rxv_d; rxf_q <= rxf_d; txl_q <= txl_d;
    end
  end

  assign oe_o = oe_q;   assign fs_o = fs_q;   assign rnw_o = rnw_q;
  assign fe_o = fe_q;   assign rxv_o = rxv_q; assign rxf_o = rxf_q;
  assign rx_o = rx_q;   assign txl_o = txl_q;

  // R10
  oe_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(scl_fall_i || start_i || stop_i));
  // R5
  no_busy_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> !$past(busy_i));
  // R3
  ack_with_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> oe_q);
  // R6
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxv_q |=> !rxv_q);
  // R9
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && !oe_q && cnt_q == '0));
  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_pins_i,
  input  logic       busy_i,
  output logic       frame_start_o,
  output logic       frame_rnw_o,
  output logic       frame_end_o,
  output logic       rx_valid_o,
  output logic       rx_first_o,
  output logic [7:0] rx_byte_o,
  output logic       tx_load_o,
  input  logic [7:0] tx_byte_i
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_slave_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .pins_i(addr_pins_i), .busy_i(busy_i), .tx_byte_i(tx_byte_i),
    .oe_o(sda_oe_o), .fs_o(frame_start_o), .rnw_o(frame_rnw_o),
    .fe_o(frame_end_o), .rxv_o(rx_valid_o), .rxf_o(rx_first_o),
    .rx_o(rx_byte_o), .txl_o(tx_load_o)
  );
endmodule

// File: tb/twi_slave_front_test.sv
module twi_slave_front_test;
  localparam int Q = 4;
  logic clk, rst_n;
  logic scl_m, sda_m, busy;
  logic [2:0] pins;
  logic [7:0] tx_byte;
  logic sda_oe, fs, rnw, fe, rxv, rxf, txl;
  logic [7:0] rxb;
  wire line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, fe_cnt = 0, txl_cnt = 0;
  bit done = 0;
  logic [8:0] rxq[$];
  logic       fsq[$];

  twi_slave_front uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe_o(sda_oe),
    .addr_pins_i(pins), .busy_i(busy), .frame_start_o(fs), .frame_rnw_o(rnw),
    .frame_end_o(fe), .rx_valid_o(rxv), .rx_first_o(rxf), .rx_byte_o(rxb),
    .tx_load_o(txl), .tx_byte_i(tx_byte)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // per-clock reference comparison of the strobes against the expected queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (rxv) begin
        if (rxq.size() == 0) chk(0, "R6 unexpected rx strobe", {rxf, rxb}, 0);
        else begin
          chk({rxf, rxb} == rxq[0], "R6 rx byte/first", {rxf, rxb}, rxq[0]);
          void'(rxq.pop_front());
        end
      end
      if (fs) begin
        if (fsq.size() == 0) chk(0, "R3 unexpected frame start", rnw, 0);
        else begin
          chk(rnw == fsq[0], "R3 direction", rnw, fsq[0]);
          void'(fsq.pop_front());
        end
      end
      if (fe) fe_cnt++;
      if (txl) txl_cnt++;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wclk(Q); scl_m = 1; wclk(Q); sda_m = 0; wclk(Q); scl_m = 0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wclk(Q); scl_m = 1; wclk(Q); sda_m = 1; wclk(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; wclk(Q); scl_m = 1; wclk(Q); seen = line; wclk(Q); scl_m = 0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(b[i], s);
      chk(s == b[i], {req, " R10 line free during master bits"}, s, b[i]);
    end
    bus_bit(1'b1, s);
    chk(s == !exp_ack, {req, " ack bit"}, s, !exp_ack);
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit mack, input logic [7:0] nxt, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      chk(s == exp[i], {req, " read bit"}, s, exp[i]);
    end
    tx_byte = nxt;
    bus_bit(!mack, s);
  endtask

  task automatic queues_empty(input string req);
    chk(rxq.size() == 0, {req, " pending rx"}, rxq.size(), 0);
    chk(fsq.size() == 0, {req, " pending frame start"}, fsq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int fe0;
    logic s;
    rst_n = 0; scl_m = 1; sda_m = 1; busy = 0; pins = 3'b101; tx_byte = 8'h00;
    wclk(5);
    rst_n = 1;
    wclk(3);
    // R1 reset state
    chk(sda_oe == 0, "R1 oe after reset", sda_oe, 0);
    chk({fs, fe, rxv, txl} == 4'b0, "R1 strobes after reset", {fs, fe, rxv, txl}, 0);

    // R2 address clocked without a start: ignored
    scl_m = 0; wclk(Q);
    send_byte(8'h5A, 0, "R2 no start");
    queues_empty("R2");
    bus_stop();

    // R3 R6 write transfer: address 0101_101_0, command, data
    fe0 = fe_cnt;
    fsq.push_back(1'b0);
    rxq.push_back({1'b1, 8'h4C});
    rxq.push_back({1'b0, 8'h3F});
    bus_start();
    send_byte(8'h5A, 1, "R3 address");
    send_byte(8'h4C, 1, "R6 command");
    send_byte(8'h3F, 1, "R6 data");
    bus_stop();
    wclk(Q);
    chk(fe_cnt == fe0 + 1, "R9 stop ends frame", fe_cnt, fe0 + 1);
    queues_empty("R6");

    // R4 wrong type code, then following byte ignored
    fe0 = fe_cnt;
    bus_start();
    send_byte(8'h7A, 0, "R4 wrong type");
    send_byte(8'h11, 0, "R4 after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'h52, 0, "R4 wrong pins");
    bus_stop();
    wclk(Q);
    chk(fe_cnt == fe0, "R4 no frame end", fe_cnt, fe0);
    queues_empty("R4");

    // R5 busy polling
    busy = 1;
    bus_start();
    send_byte(8'h5A, 0, "R5 busy poll 1");
    bus_start();
    send_byte(8'h5A, 0, "R5 busy poll 2");
    busy = 0;
    fsq.push_back(1'b0);
    bus_start();
    send_byte(8'h5A, 1, "R5 after busy");
    bus_stop();
    wclk(Q);
    queues_empty("R5");

    // R7 R8 read with master ack then nack
    txl_cnt = 0;
    tx_byte = 8'hA5;
    fsq.push_back(1'b1);
    bus_start();
    send_byte(8'h5B, 1, "R7 read address");
    read_byte(8'hA5, 1, 8'h3C, "R7 first");
    read_byte(8'h3C, 0, 8'hFF, "R8 second");
    bus_bit(1'b1, s);
    chk(s == 1'b1, "R8 released after nack", s, 1);
    chk(txl_cnt == 2, "R8 load count", txl_cnt, 2);
    bus_stop();
    wclk(Q);
    queues_empty("R8");

    // R9 repeated start in the middle of a command byte
    fe0 = fe_cnt;
    fsq.push_back(1'b0);
    fsq.push_back(1'b0);
    rxq.push_back({1'b1, 8'h0F});
    bus_start();
    send_byte(8'h5A, 1, "R9 address");
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_start();
    send_byte(8'h5A, 1, "R9 restarted address");
    send_byte(8'h0F, 1, "R9 command");
    bus_stop();
    wclk(Q);
    chk(fe_cnt == fe0 + 2, "R9 frame ends", fe_cnt, fe0 + 2);
    queues_empty("R9");

    // R3 other pin strap
    pins = 3'b010;
    bus_start();
    send_byte(8'h5A, 0, "R3 old address refused");
    fsq.push_back(1'b0);
    bus_start();
    send_byte(8'h54, 1, "R3 new address");
    bus_stop();
    wclk(Q);
    queues_empty("R3");

    summary();
  end
endmodule